// File: doc/BRIEF.md
# Cascaded First-Word-Fall-Through FIFO Chain

This block joins a parameterized number of identical first-word-fall-through FIFO stages in series. The combined capacity is the sum of the stage depths. The writer sees only the first stage's write port and full flag. The reader sees only the last stage's data, its active-low output-ready flag and its read enable. Between two stages there is no glue. The data outputs of one stage feed the data inputs of the next stage. A stage holding a word lowers its output-ready, and that low level is the next stage's write request.

All stages share one free-running clock. Because of that, a word written into an empty chain moves one stage per cycle until it appears at the read port, and the reader does not have to ask for it. Each stage always works in fall-through fashion: its oldest word is on its outputs before it is read. The hand-over from stage k to stage k+1 happens only while stage k+1 has room. On that edge stage k+1 takes the word and stage k drops it. Reset empties every stage, raises output-ready and clears full.

Top module: `fwft_chain`

## Requirements
- R1: While reset is asserted and on the first cycle after it, out_ready_n is 1 and full is 0.
- R2: Words leave the read port in exactly the order they were accepted, with none lost or repeated. A word is accepted on an edge where wr_en_n is 0 and full is 0. A word is read on an edge where rd_en_n is 0 and out_ready_n is 0. out_ready_n is 0 only while the chain holds at least one word.
- R3: With no reads, the chain accepts exactly STAGES*DEPTH words before full stays at 1. Write attempts while full is 1 leave the stored contents unchanged.
- R4: A word written into an empty chain with no read requested makes out_ready_n go to 0 after exactly STAGES rising edges, counting the edge on which the write was accepted.
- R5: While out_ready_n is 0, rd_data shows the oldest stored word. If no read happens on an edge, out_ready_n stays 0 and rd_data is unchanged after that edge.
- R6: A read request while out_ready_n is 1 has no effect. The chain stays empty, and a word written afterwards still arrives after STAGES edges with its value intact.
- R7: When the chain is full and one word is read, full returns to 0 after exactly STAGES rising edges, counting the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for every stage; runs continuously |
| rst_n | input | 1 | Asynchronous active-low reset that empties all stages |
| wr_en_n | input | 1 | Active-low write request into the first stage |
| wr_data | input | WIDTH | Word to store |
| full | output | 1 | First stage is full; writes are refused |
| rd_en_n | input | 1 | Active-low read request on the last stage |
| rd_data | output | WIDTH | Oldest word of the chain, valid while out_ready_n is 0 |
| out_ready_n | output | 1 | Active-low: last stage holds a word |

## Verification
The hardest state to reach from the ports is a completely full chain whose full flag must then release with exact timing. A single freed slot in the last stage has to travel backwards through every stage before the first stage can take a word again. The stimulus first writes on every cycle with reads held off, well beyond the total capacity. It waits for the ripple to settle, then reads exactly one word and counts the edges until full drops. A long random phase with write gaps and read stalls then makes partially filled stages pass words along while the read port stalls and resumes, and every delivered word is compared against a reference queue.

// File: rtl/fwft_chain_pkg.sv
package fwft_chain_pkg;

   typedef enum logic [1:0] {
      XF_IDLE = 2'b00,
      XF_PUSH = 2'b01,
      XF_POP  = 2'b10,
      XF_BOTH = 2'b11
   } xfer_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/fwft_stage_mem.sv
module fwft_stage_mem #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

endmodule

// File: rtl/fwft_stage_ctrl.sv
module fwft_stage_ctrl
   import fwft_chain_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_req,
   input  logic          pop_req,
   output logic          we,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] rptr,
   output logic          is_full,
   output logic          is_empty
);

   logic          push, pop;
   logic [CW-1:0] fill;
   logic [AW-1:0] wptr_nx, rptr_nx;
   xfer_e         kind;

   assign push = push_req & ~is_full;
   assign pop  = pop_req & ~is_empty;
   assign kind = xfer_e'({pop, push});
   assign we   = push;

   generate
      if (is_pow2(DEPTH)) begin : g_wrap_free
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill <= '0;
         wptr <= '0;
         rptr <= '0;
      end else begin
         case (kind)
            XF_PUSH: begin
               fill <= fill + 1'b1;
               wptr <= wptr_nx;
            end
            XF_POP: begin
               fill <= fill - 1'b1;
               rptr <= rptr_nx;
            end
            XF_BOTH: begin
               wptr <= wptr_nx;
               rptr <= rptr_nx;
            end
            default: ;
         endcase
      end
   end

   assign is_full  = (fill == CW'(DEPTH));
   assign is_empty = (fill == '0);

endmodule

// File: rtl/fwft_stage.sv
module fwft_stage #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 8,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_n,
   input  logic [WIDTH-1:0] wdata,
   output logic             full,
   input  logic             rd_n,
   output logic [WIDTH-1:0] rdata,
   output logic             ready_n
);

   logic          we;
   logic [AW-1:0] wptr, rptr;

   fwft_stage_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_req (~wr_n),
      .pop_req  (~rd_n),
      .we       (we),
      .wptr     (wptr),
      .rptr     (rptr),
      .is_full  (full),
      .is_empty (ready_n)
   );

   fwft_stage_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .we    (we),
      .waddr (wptr),
      .wdata (wdata),
      .raddr (rptr),
      .rdata (rdata)
   );

endmodule

// File: rtl/fwft_chain.sv
module fwft_chain #(
   parameter int WIDTH  = 16,
   parameter int DEPTH  = 8,
   parameter int STAGES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_n,
   input  logic [WIDTH-1:0] wr_data,
   output logic             full,
   input  logic             rd_en_n,
   output logic [WIDTH-1:0] rd_data,
   output logic             out_ready_n
);

   localparam int LAST = STAGES - 1;

   generate
      if (WIDTH < 1)  begin : g_bad_width  $error("fwft_chain: WIDTH must be at least 1");  end
      if (DEPTH < 2)  begin : g_bad_depth  $error("fwft_chain: DEPTH must be at least 2");  end
      if (STAGES < 1) begin : g_bad_stages $error("fwft_chain: STAGES must be at least 1"); end
   endgenerate

   logic [WIDTH-1:0] s_out  [STAGES];
   logic [WIDTH-1:0] s_in   [STAGES];
   logic             s_wr_n [STAGES];
   logic             s_rd_n [STAGES];
   logic             s_full [STAGES];
   logic             s_rdy_n[STAGES];

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_head
            assign s_wr_n[k] = wr_en_n;
            assign s_in[k]   = wr_data;
         end else begin : g_link
            assign s_wr_n[k] = s_rdy_n[k-1];
            assign s_in[k]   = s_out[k-1];
         end
         if (k == LAST) begin : g_tail
            assign s_rd_n[k] = rd_en_n;
         end else begin : g_pass
            assign s_rd_n[k] = s_full[k+1];
         end

         fwft_stage #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_n    (s_wr_n[k]),
            .wdata   (s_in[k]),
            .full    (s_full[k]),
            .rd_n    (s_rd_n[k]),
            .rdata   (s_out[k]),
            .ready_n (s_rdy_n[k])
         );
      end
   endgenerate

   assign full        = s_full[0];
   assign rd_data     = s_out[LAST];
   assign out_ready_n = s_rdy_n[LAST];

endmodule

// File: rtl/fwft_chain_chk.sv
module fwft_chain_chk #(
   parameter int WIDTH  = 16,
   parameter int DEPTH  = 8,
   parameter int STAGES = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en_n,
   input logic             full,
   input logic             rd_en_n,
   input logic [WIDTH-1:0] rd_data,
   input logic             out_ready_n
);

   localparam int TOTAL = DEPTH * STAGES;
   localparam int OW    = $clog2(TOTAL + 1) + 1;

   logic [OW-1:0] occ;
   logic          took_w, took_r;

   assign took_w = ~wr_en_n & ~full;
   assign took_r = ~rd_en_n & ~out_ready_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) occ <= '0;
      else        occ <= occ + OW'(took_w) - OW'(took_r);
   end

   assert_reset_R1: assert property (@(posedge clk)
      !rst_n |=> (out_ready_n && !full));

   assert_ready_has_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready_n |-> (occ != '0));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OW'(TOTAL));

   assert_full_at_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == OW'(TOTAL)) |-> full);

   assert_full_needs_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> (occ >= OW'(DEPTH)));

   assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!out_ready_n && rd_en_n) |=> (!out_ready_n && $stable(rd_data)));

endmodule

bind fwft_chain fwft_chain_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .STAGES(STAGES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en_n     (wr_en_n),
   .full        (full),
   .rd_en_n     (rd_en_n),
   .rd_data     (rd_data),
   .out_ready_n (out_ready_n)
);

// File: tb/fwft_chain_test.sv
module fwft_chain_test;

   localparam int W      = 16;
   localparam int D      = 8;
   localparam int N      = 4;
   localparam int TOTAL  = D * N;
   localparam int PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en_n = 1'b1;
   logic [W-1:0] wr_data = '0;
   logic         rd_en_n = 1'b1;
   logic         full;
   logic [W-1:0] rd_data;
   logic         out_ready_n;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] ref_q[$];

   always #(PERIOD/2) clk = ~clk;

   fwft_chain #(.WIDTH(W), .DEPTH(D), .STAGES(N)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_data(wr_data), .full(full),
      .rd_en_n(rd_en_n), .rd_data(rd_data), .out_ready_n(out_ready_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // Called just after a falling edge; covers one rising edge.
   task automatic cycle(input bit w, input logic [W-1:0] d, input bit r);
      wr_en_n = !w;
      wr_data = d;
      rd_en_n = !r;
      if (!out_ready_n) begin
         chk(ref_q.size() > 0, "R2", ref_q.size(), 1);
         if (ref_q.size() > 0)
            chk(rd_data == ref_q[0], r ? "R2" : "R5", int'(rd_data), int'(ref_q[0]));
      end
      if (r && !out_ready_n && ref_q.size() > 0) void'(ref_q.pop_front());
      if (w && !full) ref_q.push_back(d);
      @(negedge clk);
   endtask

   task automatic idle_until_ready(output int edges);
      edges = 1;
      while (out_ready_n && edges < 100) begin
         cycle(0, '0, 0);
         edges++;
      end
   endtask

   initial begin
      int edges;
      repeat (3) @(negedge clk);
      chk(out_ready_n == 1'b1, "R1", int'(out_ready_n), 1);
      chk(full == 1'b0, "R1", int'(full), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_ready_n == 1'b1, "R1", int'(out_ready_n), 1);
      chk(full == 1'b0, "R1", int'(full), 0);

      // R4: ripple latency into an empty chain
      cycle(1, 16'hA5A5, 0);
      idle_until_ready(edges);
      chk(edges == N, "R4", edges, N);
      chk(rd_data == 16'hA5A5, "R4", int'(rd_data), 16'hA5A5);
      cycle(0, '0, 1);
      cycle(0, '0, 0);
      chk(out_ready_n == 1'b1, "R2", int'(out_ready_n), 1);

      // R6: reads on an empty chain do nothing
      repeat (5) cycle(0, '0, 1);
      chk(out_ready_n == 1'b1, "R6", int'(out_ready_n), 1);
      chk(full == 1'b0, "R6", int'(full), 0);
      cycle(1, 16'h1234, 0);
      idle_until_ready(edges);
      chk(edges == N, "R6", edges, N);
      chk(rd_data == 16'h1234, "R6", int'(rd_data), 16'h1234);
      cycle(0, '0, 1);
      cycle(0, '0, 0);
      chk(ref_q.size() == 0, "R6", ref_q.size(), 0);

      // R3: fill beyond capacity without reads
      repeat (TOTAL + 5) cycle(1, W'($urandom), 0);
      repeat (2 * N) cycle(0, '0, 0);
      repeat (4) cycle(1, 16'hDEAD, 0);
      chk(ref_q.size() == TOTAL, "R3", ref_q.size(), TOTAL);
      chk(full == 1'b1, "R3", int'(full), 1);
      chk(out_ready_n == 1'b0, "R3", int'(out_ready_n), 0);

      // R7: one read frees a slot that must travel back to the head
      cycle(0, '0, 1);
      edges = 1;
      while (full && edges < 100) begin
         cycle(0, '0, 0);
         edges++;
      end
      chk(edges == N, "R7", edges, N);

      // R2: drain in order
      repeat (4 * TOTAL) cycle(0, '0, 1);
      chk(ref_q.size() == 0, "R2", ref_q.size(), 0);
      chk(out_ready_n == 1'b1, "R2", int'(out_ready_n), 1);

      // R2: random stream with random read stalls
      repeat (3000) cycle(($urandom % 4) != 0, W'($urandom), ($urandom % 3) == 0);
      repeat (3000) cycle(($urandom % 3) == 0, W'($urandom), ($urandom % 4) != 0);
      repeat (2000) cycle(($urandom % 2) == 0, W'($urandom), ($urandom % 2) == 0);
      repeat (6 * TOTAL) cycle(0, '0, 1);
      chk(ref_q.size() == 0, "R2", ref_q.size(), 0);
      chk(out_ready_n == 1'b1, "R2", int'(out_ready_n), 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule